// File: doc/BRIEF.md
# Flash Block Remapper with Dynamic Wear Leveling

This block sits between a storage front end and a small flash array and owns the table that turns a logical block number into a physical one. A read request is answered from the table one cycle later. A write is never done in place. The block picks a fresh physical block and asks the flash to program it. It then waits for the verify result. On a pass it links the logical block to the new location, marks the previous copy invalid and has it erased. On a fail it retires the block for good and retries on another one.

Each physical block carries an erase count. The target of every write is the free, healthy block with the fewest erases, which spreads wear over the array. After reset the first `NUM_LBLK` physical blocks hold the logical blocks one-to-one. The remaining `NUM_PBLK - NUM_LBLK` blocks form the spare pool. Each retirement shrinks that pool. When no free block is left, a write is refused with an error pulse and the table is left as it was.

Top module: `fwl_remap`

## Requirements
- R1: After reset every logical block L maps to physical block L, `req_ready` is 1 and `prog_valid`, `erase_valid`, `wr_done` and `wr_err` are 0.
- R2: A read accepted (`req_valid`=1, `req_write`=0, `req_ready`=1) at a clock edge gives `rd_valid`=1 for one cycle after that edge, with `rd_pblk` equal to the block currently linked to `req_lblk`.
- R3: The write target shown on `prog_pblk` is the block with the lowest erase count among blocks that are neither retired nor linked to any logical block, and ties go to the lowest index. Erase counts are all zero at reset.
- R4: On `vfy_valid`=1 with `vfy_ok`=1 while `prog_valid`=1, the written logical block is linked to `prog_pblk`. Every other logical block keeps its link, including blocks never written.
- R5: In the cycle after a passing verify, `erase_valid`=1 for exactly one cycle with `erase_pblk` equal to the block previously linked to the written logical block. That block then rejoins the free pool with its erase count raised by one. `wr_done` pulses in the following cycle.
- R6: On `vfy_valid`=1 with `vfy_ok`=0, the target block is retired and, in the next cycle, `prog_pblk` shows the next block chosen by the R3 rule for the same write.
- R7: A retired block is never shown on `prog_pblk` again.
- R8: If a write finds no free block, either at acceptance or after a failed verify, `wr_err` pulses for one cycle, `prog_valid` is 0 and the logical-to-physical links are unchanged.
- R9: `req_ready` is 0 while a write is in progress (`prog_valid` or `erase_valid` high). A request presented then is ignored and produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write (relocate), 0 = read lookup |
| req_lblk | input | clog2(NUM_LBLK) | Logical block of the request |
| req_ready | output | 1 | Block is idle and accepts a request |
| rd_valid | output | 1 | Lookup result valid (one cycle) |
| rd_pblk | output | clog2(NUM_PBLK) | Physical block for the lookup |
| prog_valid | output | 1 | Program the flash block on prog_pblk; held until verify |
| prog_pblk | output | clog2(NUM_PBLK) | Physical block chosen for the write |
| vfy_valid | input | 1 | Verify result from the flash is present |
| vfy_ok | input | 1 | 1 = programmed data verified, 0 = failed |
| erase_valid | output | 1 | Erase command (one cycle) |
| erase_pblk | output | clog2(NUM_PBLK) | Block to erase |
| wr_done | output | 1 | Write completed (one cycle) |
| wr_err | output | 1 | Write refused, no free block (one cycle) |

## Verification
The bench runs repeated writes over all but one logical block. Its own wear model predicts every target. A design that ignored erase counts, or broke ties toward the high index, would pick the wrong block and fail at once. The untouched logical block is read back after every write, which catches a table write to the wrong entry. Failed verifies are injected and the retired block is watched for: a design that only skipped it once would reuse it within a few writes. Finally the spare pool is exhausted both mid-write and at acceptance. A design that linked the logical block before verifying, or that lost the old link on refusal, would return a wrong lookup afterwards.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

    typedef enum logic [2:0] {
        BLK_FREE    = 3'd0,
        BLK_ALLOC   = 3'd1,
        BLK_USED    = 3'd2,
        BLK_INVALID = 3'd3,
        BLK_BAD     = 3'd4
    } blk_st_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } fsm_e;

endpackage

// File: rtl/fwl_map.sv
module fwl_map #(
    parameter int NUM_LBLK = 8,
    parameter int NUM_PBLK = 12,
    localparam int LW = $clog2(NUM_LBLK),
    localparam int PW = $clog2(NUM_PBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_addr,
    output logic [PW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_addr,
    input  logic [PW-1:0] wr_data
);

    typedef struct packed {
        logic [NUM_LBLK-1:0][PW-1:0] ent;
    } map_t;

    function automatic map_t map_rst();
        map_t m;
        for (int i = 0; i < NUM_LBLK; i++) begin
            m.ent[i] = PW'(i);
        end
        return m;
    endfunction

    map_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (wr_en) begin
            map_d.ent[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= map_rst();
        end else begin
            map_q <= map_d;
        end
    end

    assign rd_data = map_q.ent[rd_addr];

endmodule

// File: rtl/fwl_blktab.sv
module fwl_blktab
    import fwl_pkg::*;
#(
    parameter int NUM_LBLK = 8,
    parameter int NUM_PBLK = 12,
    parameter int CNT_W    = 8,
    localparam int PW = $clog2(NUM_PBLK)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_en,
    input  logic [PW-1:0]             alloc_idx,
    input  logic                      use_en,
    input  logic [PW-1:0]             use_idx,
    input  logic                      bad_en,
    input  logic [PW-1:0]             bad_idx,
    input  logic                      inv_en,
    input  logic [PW-1:0]             inv_idx,
    input  logic                      erase_en,
    input  logic [PW-1:0]             erase_idx,
    output logic [NUM_PBLK-1:0]       free_mask,
    output logic [NUM_PBLK*CNT_W-1:0] cnt_flat
);

    typedef struct packed {
        blk_st_e [NUM_PBLK-1:0]             st;
        logic    [NUM_PBLK-1:0][CNT_W-1:0]  cnt;
    } tab_t;

    function automatic tab_t tab_rst();
        tab_t t;
        for (int i = 0; i < NUM_PBLK; i++) begin
            t.st[i]  = (i < NUM_LBLK) ? BLK_USED : BLK_FREE;
            t.cnt[i] = '0;
        end
        return t;
    endfunction

    tab_t tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (inv_en) begin
            tab_d.st[inv_idx] = BLK_INVALID;
        end
        if (use_en) begin
            tab_d.st[use_idx] = BLK_USED;
        end
        if (bad_en) begin
            tab_d.st[bad_idx] = BLK_BAD;
        end
        if (alloc_en) begin
            tab_d.st[alloc_idx] = BLK_ALLOC;
        end
        if (erase_en) begin
            tab_d.st[erase_idx] = BLK_FREE;
            if (tab_q.cnt[erase_idx] != {CNT_W{1'b1}}) begin
                tab_d.cnt[erase_idx] = tab_q.cnt[erase_idx] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= tab_rst();
        end else begin
            tab_q <= tab_d;
        end
    end

    for (genvar g = 0; g < NUM_PBLK; g++) begin : g_free
        assign free_mask[g] = (tab_q.st[g] == BLK_FREE);
    end

    assign cnt_flat = tab_q.cnt;

endmodule

// File: rtl/fwl_pick.sv
module fwl_pick #(
    parameter int NUM_PBLK = 12,
    parameter int CNT_W    = 8,
    localparam int PW = $clog2(NUM_PBLK)
) (
    input  logic [NUM_PBLK-1:0]       free_mask,
    input  logic [NUM_PBLK*CNT_W-1:0] cnt_flat,
    output logic                      found,
    output logic [PW-1:0]             idx
);

    logic [CNT_W-1:0] best_cnt;
    logic [CNT_W-1:0] cur_cnt;

    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_cnt = '0;
        cur_cnt  = '0;
        for (int i = 0; i < NUM_PBLK; i++) begin
            cur_cnt = cnt_flat[i*CNT_W +: CNT_W];
            if (free_mask[i] && (!found || (cur_cnt < best_cnt))) begin
                found    = 1'b1;
                idx      = PW'(i);
                best_cnt = cur_cnt;
            end
        end
    end

endmodule

// File: rtl/fwl_remap.sv
module fwl_remap
    import fwl_pkg::*;
#(
    parameter int NUM_LBLK = 8,
    parameter int NUM_PBLK = 12,
    parameter int CNT_W    = 8,
    localparam int LW = $clog2(NUM_LBLK),
    localparam int PW = $clog2(NUM_PBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [LW-1:0] req_lblk,
    output logic          req_ready,
    output logic          rd_valid,
    output logic [PW-1:0] rd_pblk,
    output logic          prog_valid,
    output logic [PW-1:0] prog_pblk,
    input  logic          vfy_valid,
    input  logic          vfy_ok,
    output logic          erase_valid,
    output logic [PW-1:0] erase_pblk,
    output logic          wr_done,
    output logic          wr_err
);

    typedef struct packed {
        fsm_e          st;
        logic [LW-1:0] lblk;
        logic [PW-1:0] tgt;
        logic [PW-1:0] old;
        logic          rd_v;
        logic [PW-1:0] rd_p;
        logic          done;
        logic          err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LW-1:0]             map_rd_addr;
    logic [PW-1:0]             map_rd_data;
    logic                      map_wr_en;
    logic [LW-1:0]             map_wr_addr;
    logic [PW-1:0]             map_wr_data;

    logic                      alloc_en, use_en, bad_en, inv_en, erase_en;
    logic [PW-1:0]             alloc_idx, use_idx, bad_idx, inv_idx, erase_idx;
    logic [NUM_PBLK-1:0]       free_mask;
    logic [NUM_PBLK*CNT_W-1:0] cnt_flat;
    logic                      pick_found;
    logic [PW-1:0]             pick_idx;

    fwl_map #(
        .NUM_LBLK (NUM_LBLK),
        .NUM_PBLK (NUM_PBLK)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (map_rd_addr),
        .rd_data (map_rd_data),
        .wr_en   (map_wr_en),
        .wr_addr (map_wr_addr),
        .wr_data (map_wr_data)
    );

    fwl_blktab #(
        .NUM_LBLK (NUM_LBLK),
        .NUM_PBLK (NUM_PBLK),
        .CNT_W    (CNT_W)
    ) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_idx (alloc_idx),
        .use_en    (use_en),
        .use_idx   (use_idx),
        .bad_en    (bad_en),
        .bad_idx   (bad_idx),
        .inv_en    (inv_en),
        .inv_idx   (inv_idx),
        .erase_en  (erase_en),
        .erase_idx (erase_idx),
        .free_mask (free_mask),
        .cnt_flat  (cnt_flat)
    );

    fwl_pick #(
        .NUM_PBLK (NUM_PBLK),
        .CNT_W    (CNT_W)
    ) u_pick (
        .free_mask (free_mask),
        .cnt_flat  (cnt_flat),
        .found     (pick_found),
        .idx       (pick_idx)
    );

    // One table read port: the request address while idle, the held
    // logical block while a write is in flight.
    assign map_rd_addr = (ctl_q.st == ST_IDLE) ? req_lblk : ctl_q.lblk;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rd_v = 1'b0;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;

        map_wr_en   = 1'b0;
        map_wr_addr = ctl_q.lblk;
        map_wr_data = ctl_q.tgt;
        alloc_en    = 1'b0;
        alloc_idx   = pick_idx;
        use_en      = 1'b0;
        use_idx     = ctl_q.tgt;
        bad_en      = 1'b0;
        bad_idx     = ctl_q.tgt;
        inv_en      = 1'b0;
        inv_idx     = map_rd_data;
        erase_en    = 1'b0;
        erase_idx   = ctl_q.old;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        ctl_d.rd_v = 1'b1;
                        ctl_d.rd_p = map_rd_data;
                    end else if (pick_found) begin
                        alloc_en   = 1'b1;
                        ctl_d.tgt  = pick_idx;
                        ctl_d.lblk = req_lblk;
                        ctl_d.st   = ST_PROG;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (vfy_valid) begin
                    if (vfy_ok) begin
                        map_wr_en = 1'b1;
                        use_en    = 1'b1;
                        inv_en    = 1'b1;
                        ctl_d.old = map_rd_data;
                        ctl_d.st  = ST_ERASE;
                    end else begin
                        bad_en = 1'b1;
                        if (pick_found) begin
                            alloc_en  = 1'b1;
                            ctl_d.tgt = pick_idx;
                        end else begin
                            ctl_d.err = 1'b1;
                            ctl_d.st  = ST_IDLE;
                        end
                    end
                end
            end
            ST_ERASE: begin
                erase_en   = 1'b1;
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, lblk: '0, tgt: '0, old: '0,
                       rd_v: 1'b0, rd_p: '0, done: 1'b0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.st == ST_IDLE);
    assign rd_valid    = ctl_q.rd_v;
    assign rd_pblk     = ctl_q.rd_p;
    assign prog_valid  = (ctl_q.st == ST_PROG);
    assign prog_pblk   = ctl_q.tgt;
    assign erase_valid = (ctl_q.st == ST_ERASE);
    assign erase_pblk  = ctl_q.old;
    assign wr_done     = ctl_q.done;
    assign wr_err      = ctl_q.err;

endmodule

// File: rtl/fwl_remap_chk.sv
module fwl_remap_chk #(
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_ready,
    input logic          rd_valid,
    input logic          prog_valid,
    input logic [PW-1:0] prog_pblk,
    input logic          vfy_valid,
    input logic          vfy_ok,
    input logic          erase_valid,
    input logic [PW-1:0] erase_pblk,
    input logic          wr_done,
    input logic          wr_err
);

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_valid || erase_valid) |-> !req_ready);

    // R2
    rd_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && req_ready && !req_write));

    // R5
    erase_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_valid |-> $past(prog_valid && vfy_valid && vfy_ok));

    // R5
    erase_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_valid |=> (!erase_valid && wr_done));

    // R4
    erase_not_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_valid |-> (erase_pblk != $past(prog_pblk)));

    // R6
    retry_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_valid && vfy_valid && !vfy_ok) |=>
            (!prog_valid || (prog_pblk != $past(prog_pblk))));

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_err, wr_done, rd_valid}));

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> (!prog_valid && !erase_valid));

endmodule

bind fwl_remap fwl_remap_chk #(.PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .prog_valid  (prog_valid),
    .prog_pblk   (prog_pblk),
    .vfy_valid   (vfy_valid),
    .vfy_ok      (vfy_ok),
    .erase_valid (erase_valid),
    .erase_pblk  (erase_pblk),
    .wr_done     (wr_done),
    .wr_err      (wr_err)
);

// File: tb/fwl_remap_test.sv
`timescale 1ns/1ps
module fwl_remap_test;

    localparam int NL = 4;
    localparam int NP = 6;
    localparam int LW = $clog2(NL);
    localparam int PW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [LW-1:0] req_lblk = '0;
    logic          req_ready, rd_valid, prog_valid, erase_valid, wr_done, wr_err;
    logic [PW-1:0] rd_pblk, prog_pblk, erase_pblk;
    logic          vfy_valid = 1'b0;
    logic          vfy_ok = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    int mcnt [NP];
    bit mbad [NP];
    int mmap [NL];

    always #5 clk = ~clk;

    fwl_remap #(.NUM_LBLK(NL), .NUM_PBLK(NP), .CNT_W(8)) uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_lblk (req_lblk),
        .req_ready (req_ready), .rd_valid (rd_valid), .rd_pblk (rd_pblk),
        .prog_valid (prog_valid), .prog_pblk (prog_pblk),
        .vfy_valid (vfy_valid), .vfy_ok (vfy_ok),
        .erase_valid (erase_valid), .erase_pblk (erase_pblk),
        .wr_done (wr_done), .wr_err (wr_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected target: fewest erases among blocks neither bad nor linked, lowest index on a tie.
    function automatic int model_pick();
        int best = -1;
        for (int p = 0; p < NP; p++) begin
            bit linked = 1'b0;
            for (int l = 0; l < NL; l++) if (mmap[l] == p) linked = 1'b1;
            if (!mbad[p] && !linked && (best < 0 || mcnt[p] < mcnt[best])) best = p;
        end
        return best;
    endfunction

    task automatic do_read(input int l, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_lblk = LW'(l);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, "rd_valid", int'(rd_valid), 1);
        chk(req, $sformatf("rd_pblk L%0d", l), int'(rd_pblk), mmap[l]);
    endtask

    task automatic read_all(input string req);
        for (int l = 0; l < NL; l++) do_read(l, req);
    endtask

    task automatic do_write(input int l, input int nfail, input bit poke);
        int exp;
        int k = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_lblk = LW'(l);
        @(negedge clk);
        req_valid = 1'b0;
        exp = model_pick();
        if (exp < 0) begin
            chk("R8", "wr_err at accept", int'(wr_err), 1);
            chk("R8", "prog_valid at accept", int'(prog_valid), 0);
            return;
        end
        forever begin
            chk("R3", "prog_valid", int'(prog_valid), 1);
            chk("R3", $sformatf("prog_pblk L%0d", l), int'(prog_pblk), exp);
            chk("R7", "target not retired", int'(mbad[prog_pblk]), 0);
            if (poke) begin
                chk("R9", "req_ready busy", int'(req_ready), 0);
                req_valid = 1'b1; req_write = 1'b0; req_lblk = LW'((l + 1) % NL);
                @(negedge clk);
                req_valid = 1'b0;
                chk("R9", "no rd_valid when busy", int'(rd_valid), 0);
                chk("R9", "still programming", int'(prog_valid), 1);
                poke = 1'b0;
            end
            vfy_valid = 1'b1; vfy_ok = (k >= nfail);
            @(negedge clk);
            vfy_valid = 1'b0;
            if (k < nfail) begin
                mbad[exp] = 1'b1;
                k++;
                exp = model_pick();
                if (exp < 0) begin
                    chk("R8", "wr_err after fail", int'(wr_err), 1);
                    chk("R8", "prog_valid after fail", int'(prog_valid), 0);
                    return;
                end
                chk("R6", "retry target", int'(prog_pblk), exp);
            end else begin
                chk("R5", "erase_valid", int'(erase_valid), 1);
                chk("R5", "erase_pblk", int'(erase_pblk), mmap[l]);
                mcnt[mmap[l]]++;
                mmap[l] = exp;
                @(negedge clk);
                chk("R5", "erase one cycle", int'(erase_valid), 0);
                chk("R5", "wr_done", int'(wr_done), 1);
                return;
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin mcnt[p] = 0; mbad[p] = 1'b0; end
        for (int l = 0; l < NL; l++) mmap[l] = l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "prog_valid", int'(prog_valid), 0);
        chk("R1", "erase_valid", int'(erase_valid), 0);
        chk("R1", "wr_done", int'(wr_done), 0);
        chk("R1", "wr_err", int'(wr_err), 0);
        read_all("R1");

        // Wear sweep: logical block NL-1 is never written.
        for (int r = 0; r < 6; r++) begin
            for (int l = 0; l < NL - 1; l++) begin
                do_write(l, 0, 1'b0);
                read_all("R4");
            end
        end
        chk("R4", "unwritten keeps link", mmap[NL-1], NL - 1);

        // Busy request ignored.
        do_write(NL - 1, 0, 1'b1);
        read_all("R2");

        // One failed verify, then the retired block must stay out.
        do_write(0, 1, 1'b0);
        read_all("R6");
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < NL; l++) do_write(l, 0, 1'b0);
        end
        read_all("R7");

        // Exhaust the pool mid-write, then at acceptance.
        do_write(2, 1, 1'b0);
        read_all("R8");
        do_write(1, 0, 1'b0);
        read_all("R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule